// File: doc/BRIEF.md
# Wrapped Line Fill Controller with Early Restart

This block services a cache line miss by reading the line from memory one word at a time. The read sequence starts with the word that missed. It then wraps through the line, adding one to the word index modulo the line length, so that every word is read exactly once. Each returned word goes into a line buffer and sets that word's own valid bit. A partly filled line therefore reports exactly which of its words are usable.

The processor is released as soon as the missing word arrives. A request is completed in the same cycle that its word appears on the memory response. The rest of the line keeps filling while the processor runs on. During the fill, a processor request to the same line is served at once if its word is already valid. Otherwise the request waits until that word arrives. A request to any other line raises `line_busy` and waits until the fill has ended. Tag lookup and victim choice are outside this block: every request accepted while idle is treated as a miss.

Processor request port: `cpu_req_valid` and `cpu_req_addr` are held until `cpu_req_ready` is high. `cpu_req_ready` is combinational, and `cpu_rdata` carries the word in that same cycle. Memory request port: the controller holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is high. Memory response port: it has no ready signal. Memory returns at most one word per cycle, in the order the reads were issued, and the controller always takes it. The line length must be a power of two.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: After reset, `cpu_req_ready`, `mem_req_valid`, `line_busy` and `fill_done` are low and `word_valid` is all zero.
- R2: A request seen while idle starts a fill. The first memory read, issued in the next cycle, is for the word-aligned address of that request. The word index is address bits [4:2] and the line is bits [31:5].
- R3: Each following read keeps the line bits and sets the word index to the previous index plus one, modulo 8. Exactly 8 reads are issued per fill.
- R4: All `word_valid` bits are cleared when a fill starts. Each returned word is stored at its wrapped index and sets bit `i` of `word_valid`, where `i` is the word index. No bit is cleared during a fill.
- R5: The request that started the fill completes, with `cpu_rdata` equal to the returned word, in the same cycle that the missed word is on `mem_rsp_data`.
- R6: During a fill, a request to the same line whose word is already valid completes in the cycle it is presented, with the buffered data.
- R7: During a fill, a request to the same line whose word is not yet valid keeps `cpu_req_ready` low until that word's arrival cycle, then completes with that word.
- R8: During a fill, a request to a different line raises `line_busy`, keeps `cpu_req_ready` low and issues no read for it. It starts its own fill once the current fill has ended.
- R9: `fill_done` is high for exactly one cycle, the cycle after the eighth word is written, and all 8 valid bits are set in that cycle.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle still shows `mem_req_valid` high with the same `mem_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_addr | input | ADDR_W | Processor byte address |
| cpu_req_ready | output | 1 | Request completes this cycle, data valid |
| cpu_rdata | output | DATA_W | Word returned to the processor |
| line_busy | output | 1 | Request to another line held off by an active fill |
| word_valid | output | WORDS | Per-word valid bits of the line buffer |
| fill_done | output | 1 | One-cycle pulse after the last word is written |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Word-aligned read address |
| mem_rsp_valid | input | 1 | Returned word present |
| mem_rsp_data | input | DATA_W | Returned word |

## Verification
Some properties are checked on every cycle. These are the wrap step between consecutive reads, the first read address of a fill, the holding of a stalled read, and the fact that valid bits never clear within a fill. The same applies to `line_busy` never coinciding with a completed request, a completion without a response implying a valid word, and the shape of the done pulse. Only the directed scenarios can show the rest. That covers the full eight-address order for chosen start words, the data values handed to the processor, and the exact cycle of early restart. It also covers the wait for a word still missing and the hand-over from one fill to a queued miss on another line.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;

endpackage

// File: rtl/cwf_wrap_cnt.sv
// Counts WORDS steps starting at a base word index; the index wraps
// naturally because WORDS is a power of two.
module cwf_wrap_cnt #(
  parameter int WORDS = 8,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] base,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             more
);

  localparam logic [IDX_W:0] CNT_END = (IDX_W+1)'(WORDS);

  logic [IDX_W:0]   cnt_q;
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_END;
      base_q <= '0;
    end else if (load) begin
      cnt_q  <= '0;
      base_q <= base;
    end else if (step && more) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign more = (cnt_q < CNT_END);
  assign idx  = base_q + cnt_q[IDX_W-1:0];

endmodule

// File: rtl/cwf_line_buf.sv
// Line storage with one valid bit per word.
module cwf_line_buf #(
  parameter int WORDS  = 8,
  parameter int IDX_W  = $clog2(WORDS),
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [WORDS-1:0]  valid
);

  logic [DATA_W-1:0] slot [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] data_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (hit) data_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= 1'b0;
      else if (clear) vld_q <= 1'b0;
      else if (hit)   vld_q <= 1'b1;
    end

    assign slot[g]  = data_q;
    assign valid[g] = vld_q;
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              line_busy,
  output logic [WORDS-1:0]  word_valid,
  output logic              fill_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - BYTE_W;

  fill_state_e      st_q;
  logic [TAG_W-1:0] line_q;

  logic [TAG_W-1:0]  req_line;
  logic [IDX_W-1:0]  req_idx;
  logic              running;
  logic              start;
  logic              same_line;
  logic [IDX_W-1:0]  iss_idx;
  logic              iss_more;
  logic [IDX_W-1:0]  ret_idx;
  logic              ret_more;
  logic              rsp_wr;
  logic              arrive;
  logic [DATA_W-1:0] buf_data;

  assign req_line  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx   = cpu_req_addr[BYTE_W +: IDX_W];
  assign running   = (st_q == FILL_RUN);
  assign start     = (st_q == FILL_IDLE) && cpu_req_valid;
  assign same_line = (req_line == line_q);

  // read-issue sequence: missed word first, then wrapped order
  cwf_wrap_cnt #(.WORDS(WORDS), .IDX_W(IDX_W)) u_issue (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .base  (req_idx),
    .step  (mem_req_valid && mem_req_ready),
    .idx   (iss_idx),
    .more  (iss_more)
  );

  // return sequence: responses arrive in issue order
  cwf_wrap_cnt #(.WORDS(WORDS), .IDX_W(IDX_W)) u_return (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .base  (req_idx),
    .step  (rsp_wr),
    .idx   (ret_idx),
    .more  (ret_more)
  );

  assign rsp_wr = running && mem_rsp_valid && ret_more;

  cwf_line_buf #(.WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .wr_en   (rsp_wr),
    .wr_idx  (ret_idx),
    .wr_data (mem_rsp_data),
    .rd_idx  (req_idx),
    .rd_data (buf_data),
    .valid   (word_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FILL_IDLE;
      line_q <= '0;
    end else begin
      case (st_q)
        FILL_IDLE: if (start) begin
          st_q   <= FILL_RUN;
          line_q <= req_line;
        end
        FILL_RUN:  if (!ret_more) st_q <= FILL_IDLE;
        default:   st_q <= FILL_IDLE;
      endcase
    end
  end

  assign mem_req_valid = running && iss_more;
  assign mem_req_addr  = {line_q, iss_idx, {BYTE_W{1'b0}}};

  // early restart: a word can be forwarded in its arrival cycle
  assign arrive        = rsp_wr && (ret_idx == req_idx);
  assign cpu_req_ready = running && cpu_req_valid && same_line &&
                         (word_valid[req_idx] || arrive);
  assign cpu_rdata     = word_valid[req_idx] ? buf_data : mem_rsp_data;
  assign line_busy     = running && cpu_req_valid && !same_line;
  assign fill_done     = running && !ret_more;

endmodule

// File: rtl/cwf_fill_ctrl_chk.sv
module cwf_fill_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fill_active,
  input logic              cpu_req_valid,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_req_ready,
  input logic              line_busy,
  input logic [WORDS-1:0]  word_valid,
  input logic              fill_done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int LO     = BYTE_W + IDX_W;

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_active && cpu_req_valid) |=>
      (mem_req_valid &&
       mem_req_addr == {$past(cpu_req_addr[ADDR_W-1:BYTE_W]), {BYTE_W{1'b0}}}));

  assert_wrap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=>
      (!mem_req_valid ||
       (mem_req_addr[ADDR_W-1:LO] == $past(mem_req_addr[ADDR_W-1:LO]) &&
        mem_req_addr[LO-1:BYTE_W] == IDX_W'($past(mem_req_addr[LO-1:BYTE_W]) + 1'b1))));

  assert_valid_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_active && $past(fill_active)) |->
      ((word_valid & $past(word_valid)) == $past(word_valid)));

  assert_served_from_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_ready && !mem_rsp_valid) |-> word_valid[cpu_req_addr[BYTE_W +: IDX_W]]);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_busy |-> !cpu_req_ready);

  assert_done_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (&word_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

bind cwf_fill_ctrl cwf_fill_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WORDS  (WORDS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fill_active   (st_q == cwf_pkg::FILL_RUN),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_req_ready (cpu_req_ready),
  .line_busy     (line_busy),
  .word_valid    (word_valid),
  .fill_done     (fill_done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/cwf_fill_ctrl_bench.sv
`timescale 1ns/1ps
module cwf_fill_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic        cpu_req_ready;
  logic [31:0] cpu_rdata;
  logic        line_busy;
  logic [7:0]  word_valid;
  logic        fill_done;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  cwf_fill_ctrl u_cwf_fill_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_addr(cpu_req_addr),
    .cpu_req_ready(cpu_req_ready), .cpu_rdata(cpu_rdata),
    .line_busy(line_busy), .word_valid(word_valid), .fill_done(fill_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // memory model state
  int          mem_lat = 2;
  bit          stall_mode = 0;
  int          cyc = 0;
  logic [31:0] q_addr [16];
  int          q_due [16];
  int          q_wr = 0;
  int          q_rd = 0;
  logic [31:0] iss_log [64];
  int          iss_n = 0;
  int          hold_err = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] wrap_addr(input logic [31:0] a, input int k);
    return {a[31:5], 3'(a[4:2] + 3'(k)), 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // memory model: in-order, fixed latency, optional request stalls
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_req_ready = stall_mode ? ((cyc % 2) == 0) : 1'b1;
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_err++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        q_addr[q_wr % 16] = mem_req_addr;
        q_due[q_wr % 16]  = cyc + mem_lat;
        q_wr++;
        iss_log[iss_n % 64] = mem_req_addr;
        iss_n++;
      end
      if (q_rd != q_wr && q_due[q_rd % 16] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pat(q_addr[q_rd % 16]);
        q_rd++;
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    summary();
  end

  task automatic serve(input logic [31:0] a, output logic [31:0] d,
                       output int waits, output bit arr, output bit ok);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = a;
    waits = 0; arr = 0; ok = 0; d = '0;
    for (int i = 0; i < 300; i++) begin
      #1;
      if (cpu_req_ready) begin
        d = cpu_rdata; arr = mem_rsp_valid; ok = 1;
        break;
      end
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    logic [7:0] wv = '0;
    for (int i = 0; i < 300; i++) begin
      #1;
      if (fill_done) begin seen = 1; wv = word_valid; break; end
      @(negedge clk);
    end
    chk(seen, req, "done pulse seen", 32'(seen), 1);
    chk(wv == 8'hFF, "R9", "all valid at done", 32'(wv), 32'hFF);
    @(negedge clk); #1;
    chk(!fill_done, "R9", "done lasts one cycle", 32'(fill_done), 0);
  endtask

  task automatic chk_order(input logic [31:0] a, input int off);
    bit ok = 1;
    logic [31:0] bad = '0, exp = '0;
    chk(iss_log[off % 64] == wrap_addr(a, 0), "R2", "first read is missed word",
        iss_log[off % 64], wrap_addr(a, 0));
    for (int k = 0; k < 8; k++) begin
      if (ok && iss_log[(off + k) % 64] != wrap_addr(a, k)) begin
        ok = 0; bad = iss_log[(off + k) % 64]; exp = wrap_addr(a, k);
      end
    end
    chk(ok, "R3", "wrapped read order", bad, exp);
  endtask

  task automatic t_reset();
    #1;
    chk(!cpu_req_ready && !mem_req_valid && !line_busy && !fill_done && word_valid == 0,
        "R1", "idle outputs after reset",
        {cpu_req_ready, mem_req_valid, line_busy, fill_done, 20'h0, word_valid}, 0);
  endtask

  task automatic t_miss(input logic [31:0] a, input int lat);
    logic [31:0] d; int w; bit arr, ok; int off;
    mem_lat = lat;
    off = iss_n;
    serve(a, d, w, arr, ok);
    chk(ok && d == pat(a), "R5", "critical word data", d, pat(a));
    chk(arr, "R5", "served in arrival cycle", 32'(arr), 1);
    wait_done("R4");
    chk(iss_n - off == 8, "R3", "eight reads per fill", 32'(iss_n - off), 8);
    chk_order(a, off);
  endtask

  task automatic t_follow();
    logic [31:0] a, d; int w; bit arr, ok;
    a = 32'h0004_1248;  // word 2
    mem_lat = 2;
    serve(a, d, w, arr, ok);
    chk(d == pat(a), "R5", "critical word data", d, pat(a));
    for (int i = 0; i < 50; i++) begin
      #1; if (word_valid[3]) break;
      @(negedge clk);
    end
    serve({a[31:5], 3'd3, 2'b00}, d, w, arr, ok);
    chk(ok && w == 0, "R6", "valid word served at once", 32'(w), 0);
    chk(d == pat({a[31:5], 3'd3, 2'b00}), "R6", "buffered data", d,
        pat({a[31:5], 3'd3, 2'b00}));
    serve({a[31:5], 3'd1, 2'b00}, d, w, arr, ok);
    chk(ok && w > 0 && arr, "R7", "missing word waits for arrival", 32'(w), 1);
    chk(d == pat({a[31:5], 3'd1, 2'b00}), "R7", "late word data", d,
        pat({a[31:5], 3'd1, 2'b00}));
    wait_done("R4");
  endtask

  task automatic t_busy();
    logic [31:0] a, b, d; int w; bit arr, ok; int off, bad_rdy, other;
    bit seen;
    a = 32'h0008_0010;  // word 4
    b = 32'h000C_00E4;  // word 1 of another line
    mem_lat = 3;
    off = iss_n;
    serve(a, d, w, arr, ok);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = b;
    #1;
    chk(line_busy && !cpu_req_ready, "R8", "busy for other line",
        {30'h0, line_busy, cpu_req_ready}, 32'h2);
    bad_rdy = 0; seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (cpu_req_ready) bad_rdy++;
      if (fill_done) begin seen = 1; break; end
      @(negedge clk); #1;
    end
    chk(seen && bad_rdy == 0, "R8", "no completion while busy", 32'(bad_rdy), 0);
    other = 0;
    for (int k = 0; k < 8; k++)
      if (iss_log[(off + k) % 64][31:5] == b[31:5]) other++;
    chk(other == 0 && iss_n - off == 8, "R8", "no read for held request",
        32'(other), 0);
    @(negedge clk); @(negedge clk); #1;
    chk(word_valid == 0, "R4", "valid bits cleared at new fill", 32'(word_valid), 0);
    chk(mem_req_valid && mem_req_addr == {b[31:2], 2'b00}, "R8",
        "held miss starts its own fill", mem_req_addr, {b[31:2], 2'b00});
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      #1;
      if (cpu_req_ready) begin d = cpu_rdata; ok = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(ok && d == pat(b), "R5", "held request data", d, pat(b));
    wait_done("R4");
    chk_order(b, off + 8);
  endtask

  task automatic t_stall();
    int h0;
    stall_mode = 1;
    h0 = hold_err;
    t_miss(32'h2000_00FC, 1);  // word 7
    chk(hold_err == h0, "R10", "stalled read held", 32'(hold_err - h0), 0);
    stall_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss(32'h1000_0014, 3);  // word 5
    t_miss(32'h3000_0100, 1);  // word 0
    t_follow();
    t_busy();
    t_stall();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule